// File: doc/BRIEF.md
# Posted-Write AHB to APB Bridge

This block sits on an AHB system bus as a slave and is the sole master of a small APB segment that serves several peripherals. Each accepted AHB transfer has its address latched. The upper address field is decoded into one of several one-hot peripheral selects. The bridge then runs the two-cycle APB handshake: a setup cycle with the select high and the enable low, then an enable cycle in which the data moves. The APB side never inserts wait states, and every response is OKAY.

Writes are posted. The AHB data phase of a write finishes as soon as the APB side is free to take its data. From then on the bridge holds the address and data on APB by itself. Reads stall the AHB master until the peripheral returns data. The read data reaches AHB either straight from the peripheral in the enable cycle, or, when `REG_RDATA` is set, through a register one cycle later. The bridge keeps two address registers: one holds the transfer running on APB, the other holds the AHB data-phase transfer. The next address can therefore be taken while the current APB transfer is still running.

Top module: `ahb_apb_bridge`

## Requirements
- R1: A transfer is accepted only at a clock edge where `hsel_i`, `hready_i` and `htrans_i[1]` are all high. NONSEQ is 2'b10 and SEQ is 2'b11. IDLE (2'b00) and BUSY (2'b01) cycles, and cycles with `hsel_i` low, start nothing on APB and leave `hready_o` high.
- R2: At most one bit of `psel_o` is high in any cycle.
- R3: Every APB transfer is one setup cycle (select high, `penable_o` low) followed by exactly one enable cycle. The select and `paddr_o` stay the same across both cycles.
- R4: With `REG_RDATA`=0, a read started while APB is free has one AHB wait state. `hrdata_o` carries the selected peripheral's read data in the enable cycle.
- R5: A write whose data phase finds APB idle completes on AHB with zero wait states. It then appears on APB exactly once, with its address, select and data.
- R6: `paddr_o`, `pwrite_o` and `pwdata_o` keep their values from the setup cycle through the enable cycle. `pwdata_o` is the AHB write data of that transfer's data phase.
- R7: In a burst of back-to-back writes, the first beat has zero wait states and each later beat has exactly one.
- R8: A read whose address phase coincides with the data phase of a posted write has three wait states.
- R9: With `REG_RDATA`=1, the read data is registered in the bridge and each read has two wait states, also in back-to-back read bursts.
- R10: Peripheral n (n = 0..3) is selected when address bits [15:12] equal n. `paddr_o` carries address bits [11:0].
- R11: An address whose bits [15:12] are 4 or more raises no select and completes normally. A read of such an address returns zero.
- R12: `hresp_o` is 0 (OKAY) at all times, including reset.
- R13: With `REG_RDATA`=0, back-to-back reads each have exactly one wait state, because the next read's setup cycle follows the previous enable cycle directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared AHB/APB clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsel_i | input | 1 | Slave select from the AHB decoder |
| haddr_i | input | ADDR_W | AHB address |
| htrans_i | input | 2 | AHB transfer type |
| hwrite_i | input | 1 | AHB write direction |
| hready_i | input | 1 | AHB bus ready (previous data phase done) |
| hwdata_i | input | DATA_W | AHB write data |
| hready_o | output | 1 | Data phase completion to AHB |
| hrdata_o | output | DATA_W | Read data to AHB |
| hresp_o | output | 1 | Response, always OKAY |
| paddr_o | output | PADDR_W | APB address |
| psel_o | output | NUM_PERIPH | One-hot peripheral selects |
| penable_o | output | 1 | APB enable cycle flag |
| pwrite_o | output | 1 | APB write direction |
| pwdata_o | output | DATA_W | APB write data |
| prdata_i | input | NUM_PERIPH*DATA_W | Read data of every peripheral, peripheral n in slice n |

## Verification
The delicate cycle is the one where the data phase of a posted write finishes and a new address phase is sampled at the same edge. The write then launches onto APB while a read address, or the next write of a burst, falls into the second address register. The bench provokes this with pipelined write bursts and with a write followed at once by a read. It judges the outcome by counting `hready_o` low cycles per beat against the figures in R7 and R8. A scoreboard confirms that every posted write still appears on APB in order, with the right select, address and data.

// File: rtl/ahb_apb_pkg.sv
package ahb_apb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETUP  = 2'b01,
    PH_ENABLE = 2'b10
  } apb_ph_e;

  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;
endpackage

// File: rtl/apb_seq.sv
module apb_seq import ahb_apb_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output apb_ph_e           ph_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [DATA_W-1:0] wdata_o
);
  apb_ph_e           ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      if (ph_q == PH_SETUP) begin
        ph_q <= PH_ENABLE;
      end else begin
        ph_q <= launch_i ? PH_SETUP : PH_IDLE;
        if (launch_i) begin
          addr_q  <= addr_i;
          write_q <= write_i;
          if (write_i) wdata_q <= wdata_i;
        end
      end
    end
  end

  assign ph_o    = ph_q;
  assign addr_o  = addr_q;
  assign write_o = write_q;
  assign wdata_o = wdata_q;

  // R6: transfer fields frozen from setup into enable
  a_r6_hold_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ENABLE) |-> ($stable(addr_q) && $stable(write_q) && $stable(wdata_q)));

  // R3: a launch request never lands on a setup cycle
  a_r3_launch_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (ph_q != PH_SETUP));
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int ADDR_W     = 16,
  parameter int PADDR_W    = 12,
  parameter int NUM_PERIPH = 4
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  active_i,
  output logic [NUM_PERIPH-1:0] sel_o
);
  localparam int SEL_W = ADDR_W - PADDR_W;

  for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_sel
    assign sel_o[gi] = active_i && (addr_i[ADDR_W-1:PADDR_W] == SEL_W'(gi));
  end
endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 32
) (
  input  logic [NUM_PERIPH-1:0]        sel_i,
  input  logic [NUM_PERIPH*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]            data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel_i[i]) data_o = data_o | data_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge import ahb_apb_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int PADDR_W    = 12,
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 32,
  parameter int REG_RDATA  = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hsel_i,
  input  logic [ADDR_W-1:0]            haddr_i,
  input  logic [1:0]                   htrans_i,
  input  logic                         hwrite_i,
  input  logic                         hready_i,
  input  logic [DATA_W-1:0]            hwdata_i,
  output logic                         hready_o,
  output logic [DATA_W-1:0]            hrdata_o,
  output logic                         hresp_o,
  output logic [PADDR_W-1:0]           paddr_o,
  output logic [NUM_PERIPH-1:0]        psel_o,
  output logic                         penable_o,
  output logic                         pwrite_o,
  output logic [DATA_W-1:0]            pwdata_o,
  input  logic [NUM_PERIPH*DATA_W-1:0] prdata_i
);
  logic              accept;
  apb_ph_e           ph;
  logic              apb_free;
  logic              apb_write;
  logic [ADDR_W-1:0] apb_addr;
  // data-phase slot: second address register
  logic              dp_valid, dp_write, dp_launched;
  logic [ADDR_W-1:0] dp_addr;
  logic              rd_done;
  logic              launch_dp, launch_new, launch;
  logic [ADDR_W-1:0] launch_addr;
  logic              launch_write;
  logic              dp_done;
  logic [DATA_W-1:0] mux_data;

  assign accept   = hsel_i && hready_i && ((htrans_i == HT_NONSEQ) || (htrans_i == HT_SEQ));
  assign apb_free = (ph != PH_SETUP);

  always_comb begin
    if (!dp_valid)     hready_o = 1'b1;
    else if (dp_write) hready_o = apb_free;
    else               hready_o = rd_done;
  end
  assign dp_done = dp_valid && hready_o;

  // pending data phase wins; a fresh read may start in its own address phase
  assign launch_dp    = dp_valid && !dp_launched && apb_free;
  assign launch_new   = !launch_dp && accept && !hwrite_i && apb_free;
  assign launch       = launch_dp || launch_new;
  assign launch_addr  = launch_dp ? dp_addr : haddr_i;
  assign launch_write = launch_dp && dp_write;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid    <= 1'b0;
      dp_write    <= 1'b0;
      dp_launched <= 1'b0;
      dp_addr     <= '0;
    end else if (accept) begin
      dp_valid    <= 1'b1;
      dp_write    <= hwrite_i;
      dp_addr     <= haddr_i;
      dp_launched <= launch_new;
    end else if (dp_done) begin
      dp_valid    <= 1'b0;
      dp_launched <= 1'b0;
    end else if (launch_dp) begin
      dp_launched <= 1'b1;
    end
  end

  apb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .addr_i  (launch_addr),
    .write_i (launch_write),
    .wdata_i (hwdata_i),
    .ph_o    (ph),
    .addr_o  (apb_addr),
    .write_o (apb_write),
    .wdata_o (pwdata_o)
  );

  sel_decode #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W), .NUM_PERIPH(NUM_PERIPH)) u_dec (
    .addr_i  (apb_addr),
    .active_i(ph != PH_IDLE),
    .sel_o   (psel_o)
  );

  rd_mux #(.NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)) u_mux (
    .sel_i (psel_o),
    .data_i(prdata_i),
    .data_o(mux_data)
  );

  if (REG_RDATA != 0) begin : g_rd_reg
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_q <= '0;
        done_q  <= 1'b0;
      end else begin
        done_q <= (ph == PH_ENABLE) && !apb_write && dp_valid && !dp_write;
        if ((ph == PH_ENABLE) && !apb_write) rdata_q <= mux_data;
      end
    end
    assign rd_done  = done_q;
    assign hrdata_o = rdata_q;
  end else begin : g_rd_comb
    assign rd_done  = dp_launched && (ph == PH_ENABLE);
    assign hrdata_o = mux_data;
  end

  assign paddr_o   = apb_addr[PADDR_W-1:0];
  assign penable_o = (ph == PH_ENABLE);
  assign pwrite_o  = apb_write;
  assign hresp_o   = 1'b0;

  a_r2_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(psel_o));

  a_r3_enable_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |=> !penable_o);

  a_r3_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> ($past(!penable_o) && $stable(psel_o) && $stable(paddr_o)));

  a_r1_idle_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_o && !(hsel_i && htrans_i[1])) |=> hready_o);

  // R4 / R9: read completion only after its enable cycle has come
  a_r4_read_done_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_valid && !dp_write && hready_o) |->
      (!pwrite_o && ((REG_RDATA != 0) ? $past(penable_o) : penable_o)));
endmodule

// File: tb/sim_ahb_apb_bridge.sv
module sim_ahb_apb_bridge;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0]  sel;
    logic [11:0] addr;
    logic [31:0] data;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        hsel, use_reg, hwrite;
  logic [1:0]  htrans;
  logic [15:0] haddr;
  logic [31:0] hwdata;
  logic        hsel0, hsel1;
  assign hsel0 = hsel && !use_reg;
  assign hsel1 = hsel && use_reg;

  logic        rdy_w[2];
  logic        resp_w[2];
  logic [31:0] hrd_w[2];
  logic [3:0]  psel_w[2];
  logic        pen_w[2];
  logic        pwr_w[2];
  logic [11:0] pad_w[2];
  logic [31:0] pwd_w[2];
  logic [127:0] prd0, prd1;

  function automatic logic [31:0] periph_word(int n, logic [11:0] a);
    return 32'hC000_0000 | (32'(n) << 20) | {20'h0, a};
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    if (a[15:12] < 4'd4) return periph_word(int'(a[15:12]), a[11:0]);
    return 32'h0;
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_periph
    assign prd0[g*32 +: 32] = periph_word(g, pad_w[0]);
    assign prd1[g*32 +: 32] = periph_word(g, pad_w[1]);
  end

  ahb_apb_bridge #(.REG_RDATA(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel0), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hready_i(rdy_w[0]), .hwdata_i(hwdata), .hready_o(rdy_w[0]),
    .hrdata_o(hrd_w[0]), .hresp_o(resp_w[0]), .paddr_o(pad_w[0]), .psel_o(psel_w[0]),
    .penable_o(pen_w[0]), .pwrite_o(pwr_w[0]), .pwdata_o(pwd_w[0]), .prdata_i(prd0)
  );

  ahb_apb_bridge #(.REG_RDATA(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel1), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hready_i(rdy_w[1]), .hwdata_i(hwdata), .hready_o(rdy_w[1]),
    .hrdata_o(hrd_w[1]), .hresp_o(resp_w[1]), .paddr_o(pad_w[1]), .psel_o(psel_w[1]),
    .penable_o(pen_w[1]), .pwrite_o(pwr_w[1]), .pwdata_o(pwd_w[1]), .prdata_i(prd1)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // scoreboard queues of expected APB writes, one per instance
  wr_item_t q0[$];
  wr_item_t q1[$];

  logic        prev_pen[2];
  logic [3:0]  prev_sel[2];
  logic [11:0] prev_pad[2];
  logic [31:0] prev_pwd[2];
  logic        prev_pwr[2];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (pen_w[k]) begin
          chk($onehot0(psel_w[k]), "R2", "select not one-hot", 32'(psel_w[k]), 32'h0);
          chk(!prev_pen[k] && prev_sel[k] == psel_w[k] && prev_pad[k] == pad_w[k],
              "R3", "enable without matching setup", 32'(prev_sel[k]), 32'(psel_w[k]));
          if (pwr_w[k]) begin
            chk(prev_pwd[k] == pwd_w[k] && prev_pwr[k], "R6", "write fields moved",
                prev_pwd[k], pwd_w[k]);
          end
          if (pwr_w[k] && (psel_w[k] != 4'h0)) begin
            wr_item_t got, exp;
            got = '{sel: psel_w[k], addr: pad_w[k], data: pwd_w[k]};
            if ((k == 0 && q0.size() == 0) || (k == 1 && q1.size() == 0)) begin
              chk(1'b0, "R5", "unexpected APB write", got.data, 32'h0);
            end else begin
              exp = (k == 0) ? q0.pop_front() : q1.pop_front();
              chk(got.sel == exp.sel && got.addr == exp.addr, "R10", "APB select/addr",
                  {16'h0, got.sel, got.addr}, {16'h0, exp.sel, exp.addr});
              chk(got.data == exp.data, "R5", "APB write data", got.data, exp.data);
            end
          end
        end
        prev_pen[k] = pen_w[k];
        prev_sel[k] = psel_w[k];
        prev_pad[k] = pad_w[k];
        prev_pwd[k] = pwd_w[k];
        prev_pwr[k] = pwr_w[k];
      end
    end
  end

  logic        sq_w[8];
  logic [15:0] sq_a[8];
  logic [31:0] sq_d[8];
  int          sq_ew[8];

  task automatic set_beat(input int i, input bit w, input logic [15:0] a,
                          input logic [31:0] d, input int ew);
    sq_w[i] = w; sq_a[i] = a; sq_d[i] = d; sq_ew[i] = ew;
  endtask

  // pipelined AHB driver; called and returns at a falling edge
  task automatic run_seq(input int k, input int n, input string rq_wait, input string rq_data);
    int ap = 0;
    int dp = -1;
    int waits[8];
    logic rdy;
    for (int i = 0; i < 8; i++) waits[i] = 0;
    use_reg = (k == 1);
    for (int i = 0; i < n; i++) begin
      if (sq_w[i] && sq_a[i][15:12] < 4'd4) begin
        wr_item_t it;
        it = '{sel: 4'(1 << sq_a[i][15:12]), addr: sq_a[i][11:0], data: sq_d[i]};
        if (k == 0) q0.push_back(it); else q1.push_back(it);
      end
    end
    hsel = 1'b1;
    forever begin
      if (ap >= 0) begin
        htrans = (ap == 0) ? 2'b10 : 2'b11;
        haddr  = sq_a[ap];
        hwrite = sq_w[ap];
      end else begin
        htrans = 2'b00;
      end
      hwdata = (dp >= 0) ? sq_d[dp] : 32'h0;
      #1;
      rdy = rdy_w[k];
      if (dp >= 0) begin
        if (!rdy) begin
          waits[dp]++;
        end else begin
          chk(waits[dp] == sq_ew[dp], rq_wait, $sformatf("wait states beat %0d", dp),
              32'(waits[dp]), 32'(sq_ew[dp]));
          chk(resp_w[k] == 1'b0, "R12", "response not OKAY", 32'(resp_w[k]), 32'h0);
          if (!sq_w[dp]) begin
            chk(hrd_w[k] == exp_rd(sq_a[dp]), rq_data, $sformatf("read data beat %0d", dp),
                hrd_w[k], exp_rd(sq_a[dp]));
          end
        end
      end
      if (rdy) begin
        dp = ap;
        ap = (ap >= 0 && ap + 1 < n) ? ap + 1 : -1;
      end
      if (dp < 0 && ap < 0) break;
      @(negedge clk);
    end
    htrans = 2'b00;
    hsel   = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    hsel = 1'b0; use_reg = 1'b0; hwrite = 1'b0; htrans = 2'b00;
    haddr = 16'h0; hwdata = 32'h0;
    for (int k = 0; k < 2; k++) begin
      prev_pen[k] = 1'b0; prev_sel[k] = '0; prev_pad[k] = '0;
      prev_pwd[k] = '0; prev_pwr[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(rdy_w[0] && rdy_w[1], "R1", "ready after reset", 32'(rdy_w[0]), 32'h1);
    chk(psel_w[0] == 4'h0 && !pen_w[0], "R3", "APB quiet after reset", 32'(psel_w[0]), 32'h0);
    chk(resp_w[0] == 1'b0 && resp_w[1] == 1'b0, "R12", "OKAY after reset", 32'(resp_w[0]), 32'h0);

    // R1: BUSY with select, then NONSEQ without select: nothing starts
    hsel = 1'b1; htrans = 2'b01; haddr = 16'h1004; hwrite = 1'b1; use_reg = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(rdy_w[0] && psel_w[0] == 4'h0 && !pen_w[0], "R1", "BUSY ignored",
          32'(psel_w[0]), 32'h0);
    end
    hsel = 1'b0; htrans = 2'b10;
    repeat (3) begin
      @(negedge clk);
      chk(rdy_w[0] && psel_w[0] == 4'h0 && !pen_w[0], "R1", "unselected ignored",
          32'(psel_w[0]), 32'h0);
    end
    htrans = 2'b00;
    @(negedge clk);

    // R5: single posted write
    set_beat(0, 1'b1, 16'h1040, 32'hDEAD_0001, 0);
    run_seq(0, 1, "R5", "R5");

    // R4: single read, unregistered
    set_beat(0, 1'b0, 16'h2084, 32'h0, 1);
    run_seq(0, 1, "R4", "R4");

    // R7: write burst over all four peripherals
    set_beat(0, 1'b1, 16'h0010, 32'h1111_0000, 0);
    set_beat(1, 1'b1, 16'h1020, 32'h2222_0001, 1);
    set_beat(2, 1'b1, 16'h2030, 32'h3333_0002, 1);
    set_beat(3, 1'b1, 16'h3FFC, 32'h4444_0003, 1);
    run_seq(0, 4, "R7", "R7");

    // R8: write then read at once
    set_beat(0, 1'b1, 16'h3100, 32'hCAFE_F00D, 0);
    set_beat(1, 1'b0, 16'h0204, 32'h0, 3);
    run_seq(0, 2, "R8", "R8");

    // R13: back-to-back reads
    set_beat(0, 1'b0, 16'h0008, 32'h0, 1);
    set_beat(1, 1'b0, 16'h1ABC, 32'h0, 1);
    set_beat(2, 1'b0, 16'h3FF0, 32'h0, 1);
    run_seq(0, 3, "R13", "R10");

    // R11: unmapped read and unmapped write
    set_beat(0, 1'b0, 16'h7123, 32'h0, 1);
    run_seq(0, 1, "R11", "R11");
    set_beat(0, 1'b1, 16'hF00C, 32'hBAD0_BAD0, 0);
    run_seq(0, 1, "R11", "R11");

    // R9: registered read path
    set_beat(0, 1'b0, 16'h2010, 32'h0, 2);
    run_seq(1, 1, "R9", "R9");
    set_beat(0, 1'b0, 16'h0100, 32'h0, 2);
    set_beat(1, 1'b0, 16'h3200, 32'h0, 2);
    run_seq(1, 2, "R9", "R9");

    chk(q0.size() == 0 && q1.size() == 0, "R5", "posted writes left unseen",
        32'(q0.size() + q1.size()), 32'h0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule